// File: doc/BRIEF.md
# Discrete-Sync Video Capture with Crop Window

This block takes a parallel pixel stream (packed YUV words) that arrives with separate horizontal and vertical sync lines and, optionally, a data-enable line. It finds where each frame and each line begins and keeps a column and row position for every sample. A crop window, set by software, passes only the wanted pixels to a valid/ready output stream. The output marks the first pixel of each frame and the last pixel of each line.

The data-enable line can be turned off. In that case a line is timed only from one horizontal sync rising edge to the next. Every sample in that span counts as a pixel, including the horizontal blanking. The crop window then removes the blanking before anything reaches the output.

A frame begins only when the vertical sync pulse is long enough. It must span a set number of horizontal sync rising edges, or a set number of clock cycles. The second option covers sources whose horizontal sync stops during vertical sync. Shorter pulses are treated as glitches and have no effect. Each sync input has its own polarity setting, so active-high "valid" strobes can act as syncs. The crop settings are taken only when a frame is accepted.

Top module: `vcap_crop_top`

## Requirements
- R1: When `cfg_hs_inv_i` or `cfg_vs_inv_i` is 1, the matching sync input is inverted before edge detection. An inverted stream with the inversion bits set gives the same output beats as the non-inverted stream with the bits clear.
- R2: A frame is accepted when vertical sync (after polarity) has stayed high across `cfg_vs_min_lines_i` horizontal sync rising edges, counting the edge that arrives with the rising vertical sync. The first horizontal sync rising edge after the accepting one starts row 0.
- R3: A vertical sync pulse that ends before either acceptance condition is met starts no frame. After reset, such a pulse followed by lines of data produces no output beat.
- R4: When `cfg_vs_min_clks_i` is non-zero, a frame is also accepted once vertical sync has been high for that many clock cycles. This works even when horizontal sync does not toggle during vertical sync. Row 0 is then the first horizontal sync rising edge after acceptance.
- R5: With `cfg_de_en_i` = 0, every sample is a pixel. The sample that comes with the horizontal sync rising edge is column 0, and blanking samples take the columns that follow.
- R6: With `cfg_de_en_i` = 1, only samples with `de_i` high are pixels. Column 0 is the first such sample after the horizontal sync rising edge.
- R7: Only pixels with x0 <= column < x0+width and y0 <= row < y0+height are emitted. They come out in raster order with their data unchanged.
- R8: `m_sof_o` is 1 only on the beat at (x0, y0). `m_eol_o` is 1 only on beats whose column is x0+width-1.
- R9: The crop inputs are sampled only at frame acceptance. Changing them in the middle of a frame has no effect on that frame's beats.
- R10: While a beat is held (`m_valid_o`=1 and `m_ready_i`=0), its data and markers stay stable. A window pixel that arrives in that state is dropped, and `ovf_o` is set and stays set until reset.
- R11: During and right after reset, `m_valid_o` and `ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_data_i | input | DW | Incoming pixel word |
| hsync_i | input | 1 | Horizontal sync, raw polarity |
| vsync_i | input | 1 | Vertical sync, raw polarity |
| de_i | input | 1 | Data enable (used only if enabled) |
| cfg_hs_inv_i | input | 1 | Invert horizontal sync |
| cfg_vs_inv_i | input | 1 | Invert vertical sync |
| cfg_de_en_i | input | 1 | Use data enable to qualify pixels |
| cfg_crop_x0_i | input | XW | First cropped column |
| cfg_crop_w_i | input | XW | Cropped width in pixels |
| cfg_crop_y0_i | input | YW | First cropped row |
| cfg_crop_h_i | input | YW | Cropped height in rows |
| cfg_vs_min_lines_i | input | VLW | Minimum vertical sync length in line edges |
| cfg_vs_min_clks_i | input | VCW | Minimum vertical sync length in clocks, 0 = off |
| m_ready_i | input | 1 | Output stream ready |
| m_valid_o | output | 1 | Output stream valid |
| m_data_o | output | DW | Output pixel word |
| m_sof_o | output | 1 | First pixel of the cropped frame |
| m_eol_o | output | 1 | Last pixel of a cropped line |
| ovf_o | output | 1 | Sticky drop flag |

## Verification
A wrong column or row counter shows up as beats whose data words (built from the source row and column) are shifted. It also shows up as a wrong beat count, and this appears within the first cropped line after acceptance. A wrong acceptance state shows up in different ways. A missed frame gives no beats at all. A false acceptance on a short pulse gives beats where none are expected. An early or late acceptance moves every row by one. A wrong window latch shows up as beats taken from a changed column range. A broken hold register shows up on the ports as a held beat whose data changes, or as a missing or extra overflow flag, one clock after the stall begins.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  // Position tracker state: no frame yet, frame accepted but no line, inside lines
  typedef enum logic [1:0] {
    LN_IDLE    = 2'd0,
    LN_PENDING = 2'd1,
    LN_ACTIVE  = 2'd2
  } line_st_e;
endpackage

// File: rtl/vcap_sync_detect.sv
// Input register, polarity correction, edge detection and vertical sync qualification.
module vcap_sync_detect #(
  parameter int DW  = 16,
  parameter int VLW = 4,
  parameter int VCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  data_i,
  input  logic           hsync_i,
  input  logic           vsync_i,
  input  logic           de_i,
  input  logic           hs_inv_i,
  input  logic           vs_inv_i,
  input  logic [VLW-1:0] min_lines_i,
  input  logic [VCW-1:0] min_clks_i,
  output logic [DW-1:0]  s_data_o,
  output logic           s_de_o,
  output logic           hs_rise_o,
  output logic           frame_start_o
);
  localparam logic [VLW:0] LONE = (VLW+1)'(1);
  localparam logic [VCW:0] CONE = (VCW+1)'(1);

  logic           s_hs, s_vs, hs_q, vs_taken;
  logic [VLW-1:0] vs_lines;
  logic [VCW-1:0] vs_clks;
  logic           line_hit, clk_hit;

  always_comb begin
    hs_rise_o     = s_hs & ~hs_q;
    line_hit      = hs_rise_o && (({1'b0, vs_lines} + LONE) >= {1'b0, min_lines_i});
    clk_hit       = (min_clks_i != '0) && (({1'b0, vs_clks} + CONE) >= {1'b0, min_clks_i});
    frame_start_o = s_vs & ~vs_taken & (line_hit | clk_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_hs     <= 1'b0;
      s_vs     <= 1'b0;
      s_de_o   <= 1'b0;
      s_data_o <= '0;
      hs_q     <= 1'b0;
      vs_lines <= '0;
      vs_clks  <= '0;
      vs_taken <= 1'b0;
    end else begin
      s_hs     <= hsync_i ^ hs_inv_i;
      s_vs     <= vsync_i ^ vs_inv_i;
      s_de_o   <= de_i;
      s_data_o <= data_i;
      hs_q     <= s_hs;
      if (!s_vs) begin
        vs_lines <= '0;
        vs_clks  <= '0;
        vs_taken <= 1'b0;
      end else begin
        if (hs_rise_o && (vs_lines != '1)) vs_lines <= vs_lines + VLW'(1);
        if (vs_clks != '1)                 vs_clks  <= vs_clks + VCW'(1);
        if (frame_start_o)                 vs_taken <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vcap_pos_count.sv
// Column/row tracking; tags each qualified sample with its position.
module vcap_pos_count
  import vcap_pkg::*;
#(
  parameter int DW = 16,
  parameter int XW = 12,
  parameter int YW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_de_i,
  input  logic          hs_rise_i,
  input  logic          frame_start_i,
  input  logic          de_en_i,
  output logic          p_valid_o,
  output logic          p_fs_o,
  output logic [XW-1:0] p_x_o,
  output logic [YW-1:0] p_y_o,
  output logic [DW-1:0] p_data_o
);
  line_st_e      st;
  logic [XW-1:0] x_cnt, x_cur;
  logic [YW-1:0] y_cnt, y_cur;
  logic          qual, in_line;

  always_comb begin
    qual  = de_en_i ? s_de_i : 1'b1;
    x_cur = hs_rise_i ? '0 : x_cnt;
    y_cur = y_cnt;
    if (hs_rise_i) begin
      if (st == LN_PENDING)   y_cur = '0;
      else if (y_cnt != '1)   y_cur = y_cnt + YW'(1);
    end
    if (frame_start_i)  in_line = 1'b0;
    else if (hs_rise_i) in_line = (st != LN_IDLE);
    else                in_line = (st == LN_ACTIVE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= LN_IDLE;
      x_cnt     <= '0;
      y_cnt     <= '0;
      p_valid_o <= 1'b0;
      p_fs_o    <= 1'b0;
      p_x_o     <= '0;
      p_y_o     <= '0;
      p_data_o  <= '0;
    end else begin
      if (frame_start_i) begin
        st    <= LN_PENDING;
        y_cnt <= '0;
      end else if (hs_rise_i && (st != LN_IDLE)) begin
        st    <= LN_ACTIVE;
        y_cnt <= y_cur;
      end
      if (qual && (x_cur != '1)) x_cnt <= x_cur + XW'(1);
      else                       x_cnt <= x_cur;
      p_valid_o <= in_line & qual;
      p_fs_o    <= frame_start_i;
      p_x_o     <= x_cur;
      p_y_o     <= y_cur;
      p_data_o  <= s_data_i;
    end
  end
endmodule

// File: rtl/vcap_crop_out.sv
// Window latch, window test and the output hold register with drop detection.
module vcap_crop_out #(
  parameter int DW = 16,
  parameter int XW = 12,
  parameter int YW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          p_valid_i,
  input  logic          p_fs_i,
  input  logic [XW-1:0] p_x_i,
  input  logic [YW-1:0] p_y_i,
  input  logic [DW-1:0] p_data_i,
  input  logic [XW-1:0] cfg_x0_i,
  input  logic [XW-1:0] cfg_w_i,
  input  logic [YW-1:0] cfg_y0_i,
  input  logic [YW-1:0] cfg_h_i,
  input  logic          m_ready_i,
  output logic          m_valid_o,
  output logic [DW-1:0] m_data_o,
  output logic          m_sof_o,
  output logic          m_eol_o,
  output logic          ovf_o
);
  localparam logic [XW:0] XONE = (XW+1)'(1);

  logic [XW-1:0] win_x0, win_w;
  logic [YW-1:0] win_y0, win_h;
  logic          win_ok;
  logic [XW:0]   x_end;
  logic [YW:0]   y_end;
  logic          in_x, in_y, hit, is_sof, is_eol, can_load;

  always_comb begin
    x_end    = {1'b0, win_x0} + {1'b0, win_w};
    y_end    = {1'b0, win_y0} + {1'b0, win_h};
    in_x     = (p_x_i >= win_x0) && ({1'b0, p_x_i} < x_end);
    in_y     = (p_y_i >= win_y0) && ({1'b0, p_y_i} < y_end);
    hit      = p_valid_i & win_ok & in_x & in_y;
    is_sof   = (p_x_i == win_x0) && (p_y_i == win_y0);
    is_eol   = ({1'b0, p_x_i} == (x_end - XONE));
    can_load = ~m_valid_o | m_ready_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_x0 <= '0;
      win_w  <= '0;
      win_y0 <= '0;
      win_h  <= '0;
      win_ok <= 1'b0;
    end else if (p_fs_i) begin
      win_x0 <= cfg_x0_i;
      win_w  <= cfg_w_i;
      win_y0 <= cfg_y0_i;
      win_h  <= cfg_h_i;
      win_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
      m_sof_o   <= 1'b0;
      m_eol_o   <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      if (hit && can_load) begin
        m_valid_o <= 1'b1;
        m_data_o  <= p_data_i;
        m_sof_o   <= is_sof;
        m_eol_o   <= is_eol;
      end else if (m_ready_i) begin
        m_valid_o <= 1'b0;
        m_sof_o   <= 1'b0;
        m_eol_o   <= 1'b0;
      end
      if (hit && !can_load) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/vcap_crop_top.sv
module vcap_crop_top #(
  parameter int DW  = 16,
  parameter int XW  = 12,
  parameter int YW  = 11,
  parameter int VLW = 4,
  parameter int VCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  pix_data_i,
  input  logic           hsync_i,
  input  logic           vsync_i,
  input  logic           de_i,
  input  logic           cfg_hs_inv_i,
  input  logic           cfg_vs_inv_i,
  input  logic           cfg_de_en_i,
  input  logic [XW-1:0]  cfg_crop_x0_i,
  input  logic [XW-1:0]  cfg_crop_w_i,
  input  logic [YW-1:0]  cfg_crop_y0_i,
  input  logic [YW-1:0]  cfg_crop_h_i,
  input  logic [VLW-1:0] cfg_vs_min_lines_i,
  input  logic [VCW-1:0] cfg_vs_min_clks_i,
  input  logic           m_ready_i,
  output logic           m_valid_o,
  output logic [DW-1:0]  m_data_o,
  output logic           m_sof_o,
  output logic           m_eol_o,
  output logic           ovf_o
);
  logic [DW-1:0] s_data, p_data;
  logic          s_de, hs_rise, frame_start;
  logic          p_valid, p_fs;
  logic [XW-1:0] p_x;
  logic [YW-1:0] p_y;

  vcap_sync_detect #(.DW(DW), .VLW(VLW), .VCW(VCW)) sync_i (
    .clk(clk), .rst(rst), .data_i(pix_data_i), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .de_i(de_i), .hs_inv_i(cfg_hs_inv_i), .vs_inv_i(cfg_vs_inv_i),
    .min_lines_i(cfg_vs_min_lines_i), .min_clks_i(cfg_vs_min_clks_i),
    .s_data_o(s_data), .s_de_o(s_de), .hs_rise_o(hs_rise), .frame_start_o(frame_start)
  );

  vcap_pos_count #(.DW(DW), .XW(XW), .YW(YW)) pos_i (
    .clk(clk), .rst(rst), .s_data_i(s_data), .s_de_i(s_de), .hs_rise_i(hs_rise),
    .frame_start_i(frame_start), .de_en_i(cfg_de_en_i),
    .p_valid_o(p_valid), .p_fs_o(p_fs), .p_x_o(p_x), .p_y_o(p_y), .p_data_o(p_data)
  );

  vcap_crop_out #(.DW(DW), .XW(XW), .YW(YW)) crop_i (
    .clk(clk), .rst(rst), .p_valid_i(p_valid), .p_fs_i(p_fs), .p_x_i(p_x), .p_y_i(p_y),
    .p_data_i(p_data), .cfg_x0_i(cfg_crop_x0_i), .cfg_w_i(cfg_crop_w_i),
    .cfg_y0_i(cfg_crop_y0_i), .cfg_h_i(cfg_crop_h_i), .m_ready_i(m_ready_i),
    .m_valid_o(m_valid_o), .m_data_o(m_data_o), .m_sof_o(m_sof_o), .m_eol_o(m_eol_o),
    .ovf_o(ovf_o)
  );
endmodule

// File: rtl/vcap_crop_chk.sv
module vcap_crop_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          m_ready_i,
  input logic          m_valid_o,
  input logic [DW-1:0] m_data_o,
  input logic          m_sof_o,
  input logic          m_eol_o,
  input logic          ovf_o
);
  // R10: a stalled beat keeps valid, data and markers
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_sof_o) && $stable(m_eol_o)));

  // R10: drop flag never clears outside reset
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  // R10: drop flag only rises after a stalled cycle
  a_r10_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(m_valid_o && !m_ready_i));

  // R11: reset clears the stream and the flag
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!m_valid_o && !ovf_o));

  // R8: markers appear only on valid beats
  a_r8_marker_valid: assert property (@(posedge clk) disable iff (rst)
    (m_sof_o || m_eol_o) |-> m_valid_o);
endmodule

bind vcap_crop_top vcap_crop_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .m_ready_i(m_ready_i), .m_valid_o(m_valid_o),
  .m_data_o(m_data_o), .m_sof_o(m_sof_o), .m_eol_o(m_eol_o), .ovf_o(ovf_o)
);

// File: tb/vcap_crop_top_tb_top.sv
module vcap_crop_top_tb_top;
  localparam int DW = 16, XW = 12, YW = 11, VLW = 4, VCW = 16;
  localparam int MAXB = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0]  pix_data = '0;
  logic hsync = 1'b0, vsync = 1'b0, de = 1'b0;
  logic hs_inv = 1'b0, vs_inv = 1'b0, de_en = 1'b0;
  logic [XW-1:0]  x0 = '0, wd = '0;
  logic [YW-1:0]  y0 = '0, ht = '0;
  logic [VLW-1:0] min_lines = VLW'(5);
  logic [VCW-1:0] min_clks = '0;
  logic ready = 1'b1;
  logic m_valid, m_sof, m_eol, ovf;
  logic [DW-1:0] m_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] cap_d [MAXB];
  logic cap_s [MAXB];
  logic cap_e [MAXB];
  int nbeat = 0;

  always #4 clk = ~clk;

  vcap_crop_top #(.DW(DW), .XW(XW), .YW(YW), .VLW(VLW), .VCW(VCW)) dut_i (
    .clk(clk), .rst(rst), .pix_data_i(pix_data), .hsync_i(hsync), .vsync_i(vsync),
    .de_i(de), .cfg_hs_inv_i(hs_inv), .cfg_vs_inv_i(vs_inv), .cfg_de_en_i(de_en),
    .cfg_crop_x0_i(x0), .cfg_crop_w_i(wd), .cfg_crop_y0_i(y0), .cfg_crop_h_i(ht),
    .cfg_vs_min_lines_i(min_lines), .cfg_vs_min_clks_i(min_clks), .m_ready_i(ready),
    .m_valid_o(m_valid), .m_data_o(m_data), .m_sof_o(m_sof), .m_eol_o(m_eol), .ovf_o(ovf)
  );

  always @(negedge clk) begin
    if (!rst && m_valid && ready && nbeat < MAXB) begin
      cap_d[nbeat] = m_data;
      cap_s[nbeat] = m_sof;
      cap_e[nbeat] = m_eol;
      nbeat = nbeat + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      hsync = hs_inv; vsync = vs_inv; de = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst = 1'b1;
    idle(3);
    rst = 1'b0;
    nbeat = 0;
    idle(4);
  endtask

  // Raw row r / column c are written into the pixel word as {r, c}
  task automatic gen_frame(input int rows, input int vs_rows, input bit hs_in_vs,
                           input int len, input int hs_len, input int de_start,
                           input int de_len, input int chg_row, input int new_x0);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < len; c++) begin
        @(posedge clk); #1;
        hsync    = ((c < hs_len) && (hs_in_vs || r >= vs_rows)) ^ hs_inv;
        vsync    = (r < vs_rows) ^ vs_inv;
        de       = (c >= de_start) && (c < de_start + de_len);
        pix_data = {r[7:0], c[7:0]};
        if (r == chg_row && c == 0) x0 = XW'(new_x0);
      end
    end
    idle(3 * len);
  endtask

  task automatic check_beats(input string req, input int cx0, input int cw, input int cy0,
                             input int ch, input int base, input int xoff);
    int k;
    check({req, " beat count"}, nbeat, cw * ch);
    k = 0;
    for (int yy = 0; yy < ch; yy++) begin
      for (int xx = 0; xx < cw; xx++) begin
        logic [7:0] er, ec;
        er = 8'(cy0 + yy + base);
        ec = 8'(cx0 + xx + xoff);
        if (k < nbeat) begin
          check({req, " data"}, {16'h0, cap_d[k]}, {16'h0, er, ec});
          check({req, " R8 sof/eol"}, {30'h0, cap_s[k], cap_e[k]},
                {30'h0, (yy == 0 && xx == 0), (xx == cw - 1)});
        end
        k++;
      end
    end
    nbeat = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 valid after reset", m_valid, 0);
    check("R11 ovf after reset", ovf, 0);
  endtask

  task automatic t_basic();
    do_reset();
    de_en = 0; x0 = 3; wd = 6; y0 = 1; ht = 3; min_lines = 5; min_clks = 0;
    gen_frame(12, 5, 1, 20, 2, 0, 0, -1, 0);
    check_beats("R2 R5 R7 line-count frame", 3, 6, 1, 3, 5, 0);
  endtask

  task automatic t_polarity();
    do_reset();
    hs_inv = 1; vs_inv = 1;
    idle(4);
    x0 = 2; wd = 4; y0 = 0; ht = 2;
    gen_frame(10, 6, 1, 16, 3, 0, 0, -1, 0);
    check_beats("R1 inverted syncs", 2, 4, 0, 2, 5, 0);
    hs_inv = 0; vs_inv = 0;
  endtask

  task automatic t_short_vs();
    do_reset();
    x0 = 0; wd = 4; y0 = 0; ht = 2;
    gen_frame(10, 3, 1, 16, 2, 0, 0, -1, 0);
    check("R3 short vsync gives no beats", nbeat, 0);
    check("R3 no valid after short vsync", m_valid, 0);
    gen_frame(10, 5, 1, 16, 2, 0, 0, -1, 0);
    check_beats("R3 R2 frame after glitch", 0, 4, 0, 2, 5, 0);
  endtask

  task automatic t_de();
    do_reset();
    de_en = 1; x0 = 2; wd = 5; y0 = 2; ht = 2;
    gen_frame(12, 5, 1, 20, 2, 4, 10, -1, 0);
    check_beats("R6 de-qualified pixels", 2, 5, 2, 2, 5, 4);
    de_en = 0;
  endtask

  task automatic t_clk_mode();
    do_reset();
    min_lines = 5; min_clks = 30; x0 = 1; wd = 3; y0 = 1; ht = 2;
    gen_frame(9, 3, 0, 20, 2, 0, 0, -1, 0);
    check_beats("R4 clock-count acceptance", 1, 3, 1, 2, 3, 0);
    min_clks = 0;
  endtask

  task automatic t_latch();
    do_reset();
    x0 = 3; wd = 4; y0 = 0; ht = 3;
    gen_frame(10, 5, 1, 16, 2, 0, 0, 6, 7);
    check_beats("R9 window held for frame", 3, 4, 0, 3, 5, 0);
    gen_frame(10, 5, 1, 16, 2, 0, 0, -1, 0);
    check_beats("R9 new window next frame", 7, 4, 0, 3, 5, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    check("R11 ovf clear before stall", ovf, 0);
    ready = 0; x0 = 2; wd = 3; y0 = 1; ht = 2;
    gen_frame(10, 5, 1, 16, 2, 0, 0, -1, 0);
    check("R10 ovf set on drop", ovf, 1);
    check("R10 held valid", m_valid, 1);
    check("R10 held data is first pixel", m_data, {8'd6, 8'd2});
    check("R10 held sof", m_sof, 1);
    @(posedge clk); #1; ready = 1;
    @(posedge clk); #1; ready = 1;
    @(negedge clk);
    check("R10 valid drops after accept", m_valid, 0);
    check("R10 ovf sticky", ovf, 1);
    check("R10 one beat delivered", nbeat, 1);
    nbeat = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_polarity();
    t_short_vs();
    t_de();
    t_clk_mode();
    t_latch();
    t_overflow();
    finish_run();
  end
endmodule